// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds a small bank of 16-bit down-counters. Each counter advances on a shared tick-enable strobe of about 1.19318 MHz. Software programs the counters one byte at a time through a single byte-wide register port. A control-word address selects a channel and either sets its counting mode or freezes a snapshot of its count. Each channel also has a data address, where the 16-bit count is written and read as a low byte followed by a high byte.

Every channel drives one output line. Three behaviours are available:
- a one-shot flag that rises at terminal count;
- a periodic rate pulse that goes low for one tick;
- a square wave.

One channel's output can also be read back as a status bit at its own address. The usual use is as a system tick source, with a second channel driving a tone line.

Top module: `itv_timer3`

## Requirements
- R1: While reset is asserted, every count is zero, every byte toggle points at the low byte, no snapshot is pending, every channel is in one-shot mode and every output line is low.
- R2: A write to the control address (3) is decoded as follows:
  - bits [7:6] select the channel, and value 3 selects nothing;
  - bits [5:4] give the command: 0 takes a snapshot and 3 programs the mode;
  - bits [3:1] give the mode, where 000 is one-shot, 010 is rate pulse and 011 is square wave;
  - bit 0 must be 0.
  Any other combination leaves the channel unchanged.
- R3: Data writes alternate low byte, then high byte:
  - The low-byte write replaces bits [7:0] of the count, halts counting and drives the output low.
  - The high-byte write stores the full 16-bit value as the period and loads the count with it (half of it in square-wave mode, at least 1).
  - Counting starts only if the value is non-zero. The output then goes high in rate and square modes, and stays low in one-shot mode.
- R4: With no snapshot pending, data reads alternate between the live count's low byte and high byte, starting with the low byte.
- R5: In one-shot mode the count decrements on each tick and wraps past zero. The output goes high on the tick that takes the count from 1 to 0, and it stays high until the next low-byte write.
- R6: In rate mode, each tick decrements the count. The output is low while the count equals 1. The tick after that reloads the period and drives the output high.
- R7: In square-wave mode, each tick decrements the count. A tick seen at a count of 1 or less instead reloads half the period (at least 1) and inverts the output.
- R8: A snapshot command captures the live count only if no snapshot is pending, and it resets the read toggle to the low byte. Reads then return the captured low byte and then the captured high byte. The high-byte read releases the snapshot. A second snapshot command made while one is pending changes nothing.
- R9: A read of the status address (4) returns channel 2's output level in bit 5, with all other bits 0.
- R10: Counts and outputs move only on a tick-enable cycle. A high-byte write of zero leaves the channel halted with its output low.
- R11: Addresses 0 to 2 are the channels' data ports. A read of the control address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count-rate strobe, one clock wide per tick |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe; a read advances the byte toggle |
| bus_addr | input | ADDR_W (3) | Register address |
| bus_wdata | input | BYTE_W (8) | Write data |
| bus_rdata | output | BYTE_W (8) | Read data, valid combinationally while bus_rd is high |
| ch_out | output | NCH (3) | Per-channel output lines |

## Verification
The bench builds the block with its default parameters:
- three channels;
- 8-bit bytes;
- the status bit at position 5 of address 4, tracking channel 2.

Ticks arrive every third clock. This makes every mode reach terminal count and reload within a few dozen clocks, so each reload and wrap is seen many times. Because there are three channels, all three modes run side by side. It also puts channel select value 3 in range, so the "no channel" control writes are exercised. With 8-bit bytes, the snapshot-versus-live reads cover both halves of the count while it moves underneath them.

// File: rtl/itv_pkg.sv
package itv_pkg;
   typedef enum logic [1:0] {
      MD_ONESHOT = 2'd0,
      MD_RATE    = 2'd1,
      MD_SQUARE  = 2'd2
   } itv_mode_e;

   localparam logic [2:0] MF_ONESHOT = 3'b000;
   localparam logic [2:0] MF_RATE    = 3'b010;
   localparam logic [2:0] MF_SQUARE  = 3'b011;

   localparam logic [1:0] CMD_SNAP   = 2'b00;
   localparam logic [1:0] CMD_WORD   = 2'b11;
endpackage

// File: rtl/itv_ctl_decode.sv
module itv_ctl_decode
   import itv_pkg::*;
#(
   parameter int NCH = 3
) (
   input  logic            ctl_wr,
   input  logic [7:0]      ctl_byte,
   output logic [NCH-1:0]  snap_req,
   output logic [NCH-1:0]  prog_req,
   output itv_mode_e       prog_mode
);
   logic [1:0] sel;
   logic [1:0] cmd;
   logic [2:0] mfield;
   logic       mode_ok;

   assign sel    = ctl_byte[7:6];
   assign cmd    = ctl_byte[5:4];
   assign mfield = ctl_byte[3:1];

   always_comb begin
      mode_ok   = 1'b1;
      prog_mode = MD_ONESHOT;
      case (mfield)
         MF_ONESHOT: prog_mode = MD_ONESHOT;
         MF_RATE:    prog_mode = MD_RATE;
         MF_SQUARE:  prog_mode = MD_SQUARE;
         default:    mode_ok   = 1'b0;
      endcase
   end

   for (genvar k = 0; k < NCH; k++) begin : g_sel
      logic hit;
      assign hit         = ctl_wr && (sel == 2'(k));
      assign snap_req[k] = hit && (cmd == CMD_SNAP);
      assign prog_req[k] = hit && (cmd == CMD_WORD) && !ctl_byte[0] && mode_ok;
   end
endmodule

// File: rtl/itv_channel.sv
module itv_channel
   import itv_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              prog_req,
   input  itv_mode_e         prog_mode,
   input  logic              snap_req,
   input  logic              data_wr,
   input  logic              data_rd,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   output logic              out,
   output logic              wr_hi,
   output logic              rd_hi,
   output logic              snapped,
   output itv_mode_e         mode
);
   localparam int CNT_W = 2 * BYTE_W;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt, per, hold;
   logic [CNT_W-1:0] full_val, start_val, src;
   logic             run;

   function automatic logic [CNT_W-1:0] half_of(input logic [CNT_W-1:0] v);
      logic [CNT_W-1:0] h;
      h = v >> 1;
      return (h == '0) ? ONE : h;
   endfunction

   assign full_val  = {wdata, cnt[BYTE_W-1:0]};
   assign start_val = (mode == MD_SQUARE) ? half_of(full_val) : full_val;
   assign src       = snapped ? hold : cnt;
   assign rdata     = rd_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];

   // counting, reload and write sequence
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         per   <= '0;
         run   <= 1'b0;
         out   <= 1'b0;
         wr_hi <= 1'b0;
         mode  <= MD_ONESHOT;
      end else begin
         if (prog_req) mode <= prog_mode;
         if (data_wr && !wr_hi) begin
            cnt[BYTE_W-1:0] <= wdata;
            run   <= 1'b0;
            out   <= 1'b0;
            wr_hi <= 1'b1;
         end else if (data_wr) begin
            per   <= full_val;
            cnt   <= start_val;
            run   <= (full_val != '0);
            out   <= (mode != MD_ONESHOT) && (full_val != '0);
            wr_hi <= 1'b0;
         end else if (run && tick_en) begin
            case (mode)
               MD_ONESHOT: begin
                  cnt <= cnt - ONE;
                  if (cnt == ONE) out <= 1'b1;
               end
               MD_RATE: begin
                  if (cnt == ONE) begin
                     cnt <= per;
                     out <= 1'b1;
                  end else begin
                     cnt <= cnt - ONE;
                     out <= (cnt - ONE) != ONE;
                  end
               end
               MD_SQUARE: begin
                  if (cnt <= ONE) begin
                     cnt <= half_of(per);
                     out <= ~out;
                  end else begin
                     cnt <= cnt - ONE;
                  end
               end
               default: cnt <= cnt;
            endcase
         end
      end
   end

   // snapshot and read toggle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold    <= '0;
         snapped <= 1'b0;
         rd_hi   <= 1'b0;
      end else if (snap_req && !snapped) begin
         hold    <= cnt;
         snapped <= 1'b1;
         rd_hi   <= 1'b0;
      end else if (data_rd) begin
         rd_hi <= ~rd_hi;
         if (snapped && rd_hi) snapped <= 1'b0;
      end
   end
endmodule

// File: rtl/itv_timer3.sv
module itv_timer3
   import itv_pkg::*;
#(
   parameter int NCH       = 3,
   parameter int BYTE_W    = 8,
   parameter int ADDR_W    = 3,
   parameter int CTL_ADDR  = 3,
   parameter int STAT_ADDR = 4,
   parameter int SPK_CH    = 2,
   parameter int SPK_BIT   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic [NCH-1:0]    ch_out
);
   if (NCH < 1 || NCH > 3) begin : g_bad_nch
      $error("NCH must be 1..3: the select field has one reserved code");
   end
   if (BYTE_W != 8) begin : g_bad_byte
      $error("BYTE_W must be 8: the control word is one byte");
   end
   if (SPK_CH >= NCH || SPK_BIT >= BYTE_W) begin : g_bad_spk
      $error("status channel or bit out of range");
   end
   if ((1 << ADDR_W) <= STAT_ADDR || CTL_ADDR < NCH || STAT_ADDR < NCH) begin : g_bad_map
      $error("address map does not fit");
   end

   logic              ctl_wr;
   logic [NCH-1:0]    snap_req, prog_req;
   itv_mode_e         prog_mode;
   logic [BYTE_W-1:0] ch_rdata [NCH];
   logic [NCH-1:0]    ch_wr_hi, ch_rd_hi, ch_snapped, ch_oneshot;

   assign ctl_wr = bus_wr && (bus_addr == ADDR_W'(CTL_ADDR));

   itv_ctl_decode #(.NCH(NCH)) u_dec (
      .ctl_wr    (ctl_wr),
      .ctl_byte  (bus_wdata),
      .snap_req  (snap_req),
      .prog_req  (prog_req),
      .prog_mode (prog_mode)
   );

   for (genvar k = 0; k < NCH; k++) begin : g_ch
      itv_mode_e m;
      logic      hit;
      assign hit = (bus_addr == ADDR_W'(k));
      itv_channel #(.BYTE_W(BYTE_W)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick_en  (tick_en),
         .prog_req (prog_req[k]),
         .prog_mode(prog_mode),
         .snap_req (snap_req[k]),
         .data_wr  (bus_wr && hit),
         .data_rd  (bus_rd && hit),
         .wdata    (bus_wdata),
         .rdata    (ch_rdata[k]),
         .out      (ch_out[k]),
         .wr_hi    (ch_wr_hi[k]),
         .rd_hi    (ch_rd_hi[k]),
         .snapped  (ch_snapped[k]),
         .mode     (m)
      );
      assign ch_oneshot[k] = (m == MD_ONESHOT);
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         for (int k = 0; k < NCH; k++)
            if (bus_addr == ADDR_W'(k)) bus_rdata = ch_rdata[k];
         if (bus_addr == ADDR_W'(STAT_ADDR)) bus_rdata[SPK_BIT] = ch_out[SPK_CH];
      end
   end
endmodule

// File: rtl/itv_timer3_chk.sv
module itv_timer3_chk #(
   parameter int NCH    = 3,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [NCH-1:0]    ch_out,
   input logic [NCH-1:0]    wr_hi,
   input logic [NCH-1:0]    rd_hi,
   input logic [NCH-1:0]    snapped,
   input logic [NCH-1:0]    oneshot
);
   // R1
   reset_low_chk: assert property (@(posedge clk) !rst_n |-> (ch_out == '0));

   // R10
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !bus_wr) |=> $stable(ch_out));

   for (genvar k = 0; k < NCH; k++) begin : g_k
      // R3
      lsb_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == ADDR_W'(k) && !wr_hi[k]) |=> !ch_out[k]);

      // R8
      snap_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && bus_addr == ADDR_W'(k) && snapped[k] && rd_hi[k]) |=> !snapped[k]);

      // R5
      oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (oneshot[k] && ch_out[k] && !(bus_wr && bus_addr == ADDR_W'(k))) |=> ch_out[k]);
   end
endmodule

bind itv_timer3 itv_timer3_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick_en (tick_en),
   .bus_wr  (bus_wr),
   .bus_rd  (bus_rd),
   .bus_addr(bus_addr),
   .ch_out  (ch_out),
   .wr_hi   (ch_wr_hi),
   .rd_hi   (ch_rd_hi),
   .snapped (ch_snapped),
   .oneshot (ch_oneshot)
);

// File: tb/sim_itv_timer3.sv
module sim_itv_timer3;
   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       tick_en = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [2:0] ch_out;

   int  n_chk = 0;
   int  n_err = 0;
   bit  tick_on = 0;
   bit  done = 0;
   int  tdiv = 0;

   // reference state: mode kept as the raw field value 0, 2 or 3
   int m_cnt[3]  = '{0, 0, 0};
   int m_per[3]  = '{0, 0, 0};
   int m_mode[3] = '{0, 0, 0};
   bit m_run[3]  = '{0, 0, 0};
   bit m_out[3]  = '{0, 0, 0};
   bit m_whi[3]  = '{0, 0, 0};
   bit m_rhi[3]  = '{0, 0, 0};
   bit m_lat[3]  = '{0, 0, 0};
   int m_hold[3] = '{0, 0, 0};

   itv_timer3 u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_out(ch_out)
   );

   always #10 clk = ~clk;

   function automatic int half(input int v);
      return (v / 2 == 0) ? 1 : v / 2;
   endfunction

   function automatic int exp_rd(input int a);
      int s;
      if (a < 3) begin
         s = m_lat[a] ? m_hold[a] : m_cnt[a];
         return m_rhi[a] ? (s >> 8) & 255 : s & 255;
      end
      if (a == 4) return m_out[2] ? 32 : 0;
      return 0;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (tick_on) begin
         tdiv = (tdiv == 2) ? 0 : tdiv + 1;
         tick_en <= (tdiv == 0);
      end else begin
         tick_en <= 1'b0;
      end
   end

   // reference model, one step per clock
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 3; c++) begin
            m_cnt[c] = 0; m_per[c] = 0; m_mode[c] = 0; m_run[c] = 0; m_out[c] = 0;
            m_whi[c] = 0; m_rhi[c] = 0; m_lat[c] = 0; m_hold[c] = 0;
         end
      end else begin
         for (int c = 0; c < 3; c++) begin
            int oc, om, v, sel, cmd, mf;
            oc = m_cnt[c];
            om = m_mode[c];
            if (bus_wr && bus_addr == 3) begin
               sel = bus_wdata >> 6;
               cmd = (bus_wdata >> 4) & 3;
               mf  = (bus_wdata >> 1) & 7;
               if (sel == c) begin
                  if (cmd == 0) begin
                     if (!m_lat[c]) begin m_lat[c] = 1; m_hold[c] = oc; m_rhi[c] = 0; end
                  end else if (cmd == 3 && bus_wdata[0] == 0 && (mf == 0 || mf == 2 || mf == 3)) begin
                     m_mode[c] = mf;
                  end
               end
            end
            if (bus_rd && bus_addr == c) begin
               if (m_lat[c] && m_rhi[c]) m_lat[c] = 0;
               m_rhi[c] = !m_rhi[c];
            end
            if (bus_wr && bus_addr == c) begin
               if (!m_whi[c]) begin
                  m_cnt[c] = (oc & 'hff00) | bus_wdata;
                  m_run[c] = 0; m_out[c] = 0; m_whi[c] = 1;
               end else begin
                  v = bus_wdata * 256 + (oc & 255);
                  m_per[c] = v;
                  m_cnt[c] = (om == 3) ? half(v) : v;
                  m_run[c] = (v != 0);
                  m_out[c] = (om != 0) && (v != 0);
                  m_whi[c] = 0;
               end
            end else if (m_run[c] && tick_en) begin
               if (om == 0) begin
                  m_cnt[c] = (oc - 1) & 'hffff;
                  if (oc == 1) m_out[c] = 1;
               end else if (om == 2) begin
                  if (oc == 1) begin m_cnt[c] = m_per[c]; m_out[c] = 1; end
                  else begin m_cnt[c] = oc - 1; m_out[c] = (oc - 1 != 1); end
               end else begin
                  if (oc <= 1) begin m_cnt[c] = half(m_per[c]); m_out[c] = !m_out[c]; end
                  else m_cnt[c] = oc - 1;
               end
            end
         end
      end
   end

   // per-clock output comparison, tagged by the channel's mode
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int c = 0; c < 3; c++) begin
            string t;
            t = (m_mode[c] == 0) ? "R5" : (m_mode[c] == 2) ? "R6" : "R7";
            chk(ch_out[c] === m_out[c], t, ch_out[c], m_out[c]);
         end
      end
   end

   task automatic op(input bit w, input bit r, input int a, input int d, input string tag);
      @(negedge clk);
      bus_wr = w; bus_rd = r; bus_addr = 3'(a); bus_wdata = 8'(d);
      if (r) begin
         #1;
         chk(bus_rdata === 8'(exp_rd(a)), tag, bus_rdata, exp_rd(a));
      end
      @(posedge clk);
      #1;
      bus_wr = 0; bus_rd = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      #2 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(ch_out === 3'b000, "R1", ch_out, 0);
      rst_n = 1'b1;
      // R1 / R4: counts read back zero after reset
      op(0, 1, 0, 0, "R1");
      op(0, 1, 0, 0, "R4");
      tick_on = 1;

      // one-shot on channel 0, period 5
      op(1, 0, 3, 8'h30, "R2");
      op(1, 0, 0, 5, "R3");
      op(1, 0, 0, 0, "R3");
      idle(24);
      @(negedge clk);
      chk(ch_out[0] === 1'b1, "R5", ch_out[0], 1);
      op(0, 1, 0, 0, "R4");
      op(0, 1, 0, 0, "R4");

      // snapshot, second snapshot ignored, read while live count moves
      op(1, 0, 3, 8'h00, "R8");
      idle(7);
      op(1, 0, 3, 8'h00, "R8");
      op(0, 1, 0, 0, "R8");
      idle(4);
      op(0, 1, 0, 0, "R8");
      op(0, 1, 0, 0, "R4");
      op(0, 1, 0, 0, "R4");

      // rate pulse on channel 1, period 4
      op(1, 0, 3, 8'h74, "R2");
      op(1, 0, 1, 4, "R3");
      op(1, 0, 1, 0, "R3");
      idle(40);
      op(0, 1, 1, 0, "R6");
      op(0, 1, 1, 0, "R6");

      // square wave on channel 2, period 6, with status reads
      op(1, 0, 3, 8'hB6, "R2");
      op(1, 0, 2, 6, "R3");
      op(1, 0, 2, 0, "R3");
      for (int i = 0; i < 12; i++) begin
         op(0, 1, 4, 0, "R9");
         idle(2);
      end

      // rejected control words on channel 1: BCD, mode 1, byte-only access, select 3
      op(1, 0, 3, 8'h75, "R2");
      op(1, 0, 3, 8'h72, "R2");
      op(1, 0, 3, 8'h50, "R2");
      op(1, 0, 3, 8'hF0, "R2");
      op(1, 0, 3, 8'hF6, "R2");
      idle(30);

      // zero period halts channel 0 with output low
      op(1, 0, 0, 0, "R10");
      op(1, 0, 0, 0, "R10");
      idle(12);
      @(negedge clk);
      chk(ch_out[0] === 1'b0, "R10", ch_out[0], 0);
      op(0, 1, 0, 0, "R10");
      op(0, 1, 0, 0, "R10");

      // low-byte write drops the square-wave output
      op(1, 0, 2, 9, "R3");
      @(negedge clk);
      chk(ch_out[2] === 1'b0, "R3", ch_out[2], 0);
      idle(10);
      op(1, 0, 2, 1, "R3");
      idle(20);

      // ticks stopped: nothing moves
      tick_on = 0;
      idle(3);
      op(0, 1, 1, 0, "R10");
      idle(10);
      op(0, 1, 1, 0, "R10");

      // control address reads zero
      op(0, 1, 3, 0, "R11");
      op(0, 1, 4, 0, "R9");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule